// File: doc/BRIEF.md
# Four-Channel Staggered PWM Generator

This block produces four pulse-width timing waveforms and four gated drive enables for low-side switches on inductive loads. One shared phase counter steps once per oscillator tick and runs through a period of 2^CW steps (16 by default). Each lane holds a duty code. A new code is taken from the `duty_in` bus only when the counter wraps, so a period is never cut short or stretched.

Lanes 0 and 2 lead: they switch on at the start of the period. Lanes 1 and 3 trail: they run in the opposite phase and switch off at the end of the period. This keeps the edges of neighbouring lanes apart and lowers the combined current slew. A duty code of zero turns the drive off. The timing waveform still runs at 15/16 in that case, so diagnostic sampling keyed to its edges keeps working.

An overcurrent trip blanks its lane's drive for the rest of the current period. A global off input blocks every drive while it is high. It does not disturb the counter or the held codes.

Top module: `stag_pwm`

## Requirements
- R1: The phase counter starts at 0, advances by one on each cycle with `osc_tick` high, holds on cycles without it, and wraps from 15 to 0.
- R2: For a held code n in 1..15, leading lanes 0 and 2 have `pwm_tmg` high exactly while counter < n.
- R3: For a held code n in 1..15, trailing lanes 1 and 3 have `pwm_tmg` high exactly while counter >= n.
- R4: With a held code of 0, `drv_en` of that lane stays low. Its `pwm_tmg` is high while counter < 15 (leading lanes) or while counter >= 1 (trailing lanes).
- R5: The code of lane k is `duty_in[4k+3:4k]`. It is captured only on the tick that moves the counter from 15 to 0, and it is used from the next cycle on.
- R6: `oc_trip[k]` high forces `drv_en[k]` low in that cycle and in every later cycle until the next wrap tick. A trip on the wrap tick itself also blanks the new period.
- R7: While `uv_off` is high, all `drv_en` bits are low. The counter and the held codes keep running, so after `uv_off` falls the waveforms continue with no break.
- R8: A synchronous reset clears the counter, all held codes and all blanking. After reset, `pwm_tmg` = 4'b0101 and `drv_en` = 0.
- R9: Without blanking and without `uv_off`, `drv_en[k]` equals `pwm_tmg[k]` for every lane with a nonzero held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle pulse that advances the phase counter |
| duty_in | input | 16 | Pending duty codes, 4 bits per lane, lane 0 in the low bits |
| uv_off | input | 1 | Global off: blocks all drive enables |
| oc_trip | input | 4 | Per-lane overcurrent trip |
| pwm_tmg | output | 4 | Per-lane PWM timing waveform |
| drv_en | output | 4 | Per-lane gated drive enable |

## Verification
The counter, the held codes and the blanking flags all register on the clock edge. The waveform and drive outputs are decoded from those registers with no further delay. The trip and off inputs reach `drv_en` in the same cycle. The bench therefore applies each stimulus at a falling edge and compares the outputs a moment later against a reference model. The model's state is updated at the following rising edge, so every check sees the same registered state as the design. A code written to `duty_in` shows on the outputs in the cycle after the wrap tick. Blanking from a trip starts in the trip cycle and lasts through the next wrap tick. The model tracks both of these timings exactly.

// File: rtl/stag_pwm_pkg.sv
package stag_pwm_pkg;
    localparam int unsigned DEF_CW   = 4;
    localparam int unsigned DEF_CH_N = 4;
endpackage

// File: rtl/stag_pwm_tbase.sv
module stag_pwm_tbase #(
    parameter int unsigned CW = stag_pwm_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (osc_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign wrap = osc_tick && (st_q.cnt == LAST);
endmodule

// File: rtl/stag_pwm_lane.sv
module stag_pwm_lane #(
    parameter int unsigned CW    = stag_pwm_pkg::DEF_CW,
    parameter bit          TRAIL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] code_in,
    input  logic          oc_trip,
    input  logic          uv_off,
    output logic          tmg,
    output logic          drv,
    output logic [CW-1:0] code
);
    localparam logic [CW-1:0] FULL = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] code;
        logic          blank;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     code_zero;
    logic [CW-1:0] thr;

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.code  = code_in;
            st_d.blank = oc_trip;
        end else begin
            st_d.blank = st_q.blank | oc_trip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_zero = (st_q.code == '0);

    generate
        if (TRAIL) begin : g_trail
            assign thr = code_zero ? ONE : st_q.code;
            assign tmg = (cnt >= thr);
        end else begin : g_lead
            assign thr = code_zero ? FULL : st_q.code;
            assign tmg = (cnt < thr);
        end
    endgenerate

    assign drv  = tmg && !code_zero && !st_q.blank && !oc_trip && !uv_off;
    assign code = st_q.code;
endmodule

// File: rtl/stag_pwm.sv
module stag_pwm #(
    parameter int unsigned CW   = stag_pwm_pkg::DEF_CW,
    parameter int unsigned CH_N = stag_pwm_pkg::DEF_CH_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               osc_tick,
    input  logic [CH_N*CW-1:0] duty_in,
    input  logic               uv_off,
    input  logic [CH_N-1:0]    oc_trip,
    output logic [CH_N-1:0]    pwm_tmg,
    output logic [CH_N-1:0]    drv_en
);
    logic [CW-1:0]      cnt;
    logic               wrap;
    logic [CH_N*CW-1:0] code_hold;

    stag_pwm_tbase #(.CW(CW)) u_tbase (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    for (genvar k = 0; k < CH_N; k++) begin : g_lane
        stag_pwm_lane #(.CW(CW), .TRAIL((k % 2) == 1)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .wrap    (wrap),
            .cnt     (cnt),
            .code_in (duty_in[k*CW +: CW]),
            .oc_trip (oc_trip[k]),
            .uv_off  (uv_off),
            .tmg     (pwm_tmg[k]),
            .drv     (drv_en[k]),
            .code    (code_hold[k*CW +: CW])
        );
    end
endmodule

// File: rtl/stag_pwm_chk.sv
module stag_pwm_chk #(
    parameter int unsigned CW   = stag_pwm_pkg::DEF_CW,
    parameter int unsigned CH_N = stag_pwm_pkg::DEF_CH_N
) (
    input logic               clk,
    input logic               rst,
    input logic               osc_tick,
    input logic               uv_off,
    input logic [CH_N-1:0]    oc_trip,
    input logic [CH_N-1:0]    pwm_tmg,
    input logic [CH_N-1:0]    drv_en,
    input logic [CW-1:0]      cnt,
    input logic               wrap,
    input logic [CH_N*CW-1:0] codes
);
    a_r7_off_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        uv_off |-> (drv_en == '0));

    a_r9_drive_inside_timing: assert property (@(posedge clk) disable iff (rst)
        ((drv_en & ~pwm_tmg) == '0));

    a_r1_count_holds: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> $stable(cnt));

    a_r1_count_steps: assert property (@(posedge clk) disable iff (rst)
        osc_tick |=> (cnt == CW'($past(cnt) + 1'b1)));

    a_r5_codes_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(codes));

    for (genvar k = 0; k < CH_N; k++) begin : g_chk
        a_r6_trip_blanks: assert property (@(posedge clk) disable iff (rst)
            (oc_trip[k] && !wrap) |=> !drv_en[k]);

        a_r4_zero_no_drive: assert property (@(posedge clk) disable iff (rst)
            (codes[k*CW +: CW] == '0) |-> !drv_en[k]);
    end
endmodule

bind stag_pwm stag_pwm_chk #(.CW(CW), .CH_N(CH_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .uv_off   (uv_off),
    .oc_trip  (oc_trip),
    .pwm_tmg  (pwm_tmg),
    .drv_en   (drv_en),
    .cnt      (cnt),
    .wrap     (wrap),
    .codes    (code_hold)
);

// File: tb/stag_pwm_bench.sv
`timescale 1ns/1ps
module stag_pwm_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic [15:0] duty_in = '0;
    logic        uv_off = 1'b0;
    logic [3:0]  oc_trip = '0;
    logic [3:0]  pwm_tmg;
    logic [3:0]  drv_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [3:0] m_cnt;
    logic [3:0] m_code [4];
    logic [3:0] m_blank;

    always #5 clk = ~clk;

    stag_pwm u_stag_pwm (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .duty_in  (duty_in),
        .uv_off   (uv_off),
        .oc_trip  (oc_trip),
        .pwm_tmg  (pwm_tmg),
        .drv_en   (drv_en)
    );

    // Leading lanes: on for the first c steps; code 0 means 15 steps.
    // Trailing lanes: off for the first c steps; code 0 means 1 step off.
    function automatic logic want_tmg(int k, logic [3:0] c, logic [3:0] n);
        int on_steps;
        if (k % 2 == 0) begin
            on_steps = (c == 0) ? 15 : int'(c);
            return int'(n) < on_steps;
        end
        on_steps = (c == 0) ? 15 : 16 - int'(c);
        return int'(n) >= 16 - on_steps;
    endfunction

    function automatic logic [7:0] want_out();
        logic [3:0] t, d;
        for (int k = 0; k < 4; k++) begin
            t[k] = want_tmg(k, m_code[k], m_cnt);
            d[k] = t[k] && (m_code[k] != 0) && !m_blank[k] && !oc_trip[k] && !uv_off;
        end
        return {t, d};
    endfunction

    task automatic model_step();
        logic w;
        if (rst) begin
            m_cnt = '0; m_blank = '0;
            for (int k = 0; k < 4; k++) m_code[k] = '0;
        end else begin
            w = osc_tick && (m_cnt == 4'hF);
            if (osc_tick) m_cnt = m_cnt + 4'd1;
            for (int k = 0; k < 4; k++) begin
                if (w) begin
                    m_code[k]  = duty_in[4*k +: 4];
                    m_blank[k] = oc_trip[k];
                end else begin
                    m_blank[k] = m_blank[k] | oc_trip[k];
                end
            end
        end
    endtask

    // Called at a falling edge with the inputs already applied.
    task automatic check_step(string req);
        logic [7:0] exp_v, act_v;
        #1;
        exp_v = want_out();
        act_v = {pwm_tmg, drv_en};
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s cnt=%0d tmg/drv actual=%b expected=%b", req, m_cnt, act_v, exp_v);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic run(int cycles, int tick_every, logic [15:0] duty, string req);
        for (int i = 0; i < cycles; i++) begin
            osc_tick = (i % tick_every) == 0;
            duty_in  = duty;
            check_step(req);
        end
    endtask

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_cnt = '0; m_blank = '0;
        for (int k = 0; k < 4; k++) m_code[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        check_step("R8");
        // R1, R2, R3: counter sweep with mixed codes, then stalled ticks
        run(40, 1, 16'h3A5C, "R1 R2 R3 R9");
        run(60, 3, 16'h3A5C, "R1 stall");
        // R2, R3 boundaries: codes 1 and 15
        run(36, 1, 16'hF1F1, "R2 R3 edge");
        run(36, 1, 16'h1F1F, "R2 R3 edge");
        // R4: zero codes keep 15/16 timing with drive off
        run(36, 1, 16'h0F00, "R4");
        // R5: change pending code mid-period; takes effect only after wrap
        run(8, 1, 16'h2222, "R5");
        run(30, 1, 16'hEEEE, "R5");
        // R6: trips mid-period and on the wrap tick
        duty_in = 16'h8888;
        while (m_cnt != 4'd5) begin osc_tick = 1'b1; check_step("R6"); end
        oc_trip = 4'b0101; check_step("R6");
        oc_trip = 4'b0000; run(14, 1, 16'h8888, "R6");
        while (m_cnt != 4'hF) begin osc_tick = 1'b1; check_step("R6"); end
        oc_trip = 4'b1010; check_step("R6 wrap");
        oc_trip = 4'b0000; run(20, 1, 16'h8888, "R6");
        // R7: global off does not stop counter or codes
        uv_off = 1'b1; run(25, 1, 16'h6666, "R7");
        uv_off = 1'b0; run(20, 1, 16'h6666, "R7");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            osc_tick = ($urandom % 2) == 0;
            if ($urandom % 20 == 0) duty_in = 16'($urandom);
            uv_off  = ($urandom % 40) == 0;
            oc_trip = (($urandom % 25) == 0) ? 4'($urandom) : 4'b0000;
            check_step("R2 R3 R6 R7 random");
        end

        // R8: reset mid-run
        rst = 1'b1; osc_tick = 1'b0; oc_trip = '0; uv_off = 1'b0;
        @(posedge clk); model_step(); @(negedge clk);
        rst = 1'b0;
        check_step("R8 rerun");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule